// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is an eight-tap finite impulse response filter whose coefficients mirror about the centre, h[k] = h[7-k]. The mirrored taps give the filter linear phase, so every frequency is delayed by the same amount. The symmetry also lets the block share hardware. The two samples that meet the same coefficient are summed first, and that sum is multiplied once. Four multipliers therefore serve all eight taps.

Samples arrive with a valid strobe and shift into a delay line. A registered product stage and a registered sum stage follow, so each result leaves two clock edges after its sample was captured. The four distinct coefficients are held in a small register bank. A single-cycle write port can reload that bank at run time, which changes the response without a reset.

Top module: `foldedFir`

## Requirements
- R1: While `rst` is high at a rising edge, the delay line, the product stage and the output are cleared. After the reset, `outValid` is 0 and `dataOut` is 0, and all four coefficients hold the default value 65.
- R2: A sample captured at a rising edge where `inValid` is 1 produces exactly one `outValid` pulse, seen in the cycle after the second following rising edge. No `outValid` pulse occurs without a captured sample.
- R3: The output is y = c0·(x0+x7) + c1·(x1+x6) + c2·(x2+x5) + c3·(x3+x4), with unsigned arithmetic. Here x0 is the newest captured sample and x7 is the oldest. Coefficient address 0 holds c0 and address 3 holds c3.
- R4: When `inValid` is 0, the delay line does not shift, and `dataOut` keeps its value while `outValid` is 0.
- R5: When `coefWe` is 1 at a rising edge, `coefData` is stored into the coefficient selected by `coefAddr`. Every product formed at a later edge uses the new value.
- R6: With all samples and all coefficients at 1023, the output is 8372232 and does not wrap.
- R7: When `coefWe` is 0, `coefAddr` and `coefData` have no effect on the coefficients.
- R8: A reset applied after coefficient writes restores every coefficient to 65.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Capture `dataIn` into the delay line |
| dataIn | input | 10 | Unsigned input sample |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 2 | Selects the coefficient (c0 to c3) to write |
| coefData | input | 10 | Unsigned coefficient value |
| outValid | output | 1 | Marks a new filter result |
| dataOut | output | 23 | Unsigned filter result |

## Verification
Each result is due two rising edges after the edge that captured its sample. The bench therefore stamps every sample it drives with that due cycle and queues the expected convolution value beside it. At each falling edge the bench compares any `outValid` pulse with the head of the queue, checking both the cycle and the value. A pulse that arrives late, arrives without a queued sample, or is missing is reported against R2. Coefficient writes are made only after the pipeline has drained, so every queued value uses a single, known coefficient set.

// File: rtl/firPkg.sv
package firPkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic shiftEn;   // shift a new sample into the delay line
    logic prodEn;    // load the product registers
    logic sumEn;     // load the output sum register
    logic coefWe;    // write one coefficient
  } ctrlStrobes_t;

endpackage

// File: rtl/firControl.sv
module firControl
  import firPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         coefWe,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic prodStage;
  logic sumStage;
  logic validOut;
  logic [1:0] warmCnt;

  // Valid pipeline: one stage for products, one for the sum, one for the output flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      prodStage <= 1'b0;
      sumStage  <= 1'b0;
      validOut  <= 1'b0;
    end else begin
      prodStage <= inValid;
      sumStage  <= prodStage;
      validOut  <= sumStage;
    end
  end

  // Counts edges since reset, saturating at 3 (used only by the assertion).
  always_ff @(posedge clk) begin
    if (rst)                 warmCnt <= 2'd0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  always_comb begin
    strobes.shiftEn = inValid;
    strobes.prodEn  = prodStage;
    strobes.sumEn   = sumStage;
    strobes.coefWe  = coefWe;
  end

  assign outValid = validOut;

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warmCnt == 2'd3) |-> (outValid == $past(inValid, 3))) else $error("latency"); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !outValid) else $error("reset valid"); // R1

endmodule

// File: rtl/firDatapath.sv
module firDatapath
  import firPkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int COEF_W   = 10,
  parameter int TAPS     = 8,
  parameter int DEF_COEF = 65,
  localparam int PAIRS   = TAPS / 2,
  localparam int ADDR_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int PRE_W   = DATA_W + 1,
  localparam int PROD_W  = PRE_W + COEF_W,
  localparam int SUM_W   = PROD_W + $clog2(PAIRS)
)(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic [COEF_W-1:0] coefData,
  output logic [SUM_W-1:0]  dataOut
);

  logic [DATA_W-1:0] taps     [TAPS];
  logic [COEF_W-1:0] coefBank [PAIRS];
  logic [PRE_W-1:0]  preSum   [PAIRS];
  logic [PROD_W-1:0] prodReg  [PAIRS];
  logic [SUM_W-1:0]  sumNext;
  logic [SUM_W-1:0]  sumReg;

  // Delay line: taps[0] holds the newest sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else if (strobes.shiftEn) begin
      taps[0] <= dataIn;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // One fold per coefficient: pre-add the mirrored pair, multiply, register.
  for (genvar k = 0; k < PAIRS; k++) begin : g_fold
    always_ff @(posedge clk) begin
      if (rst)                                                coefBank[k] <= COEF_W'(DEF_COEF);
      else if (strobes.coefWe && coefAddr == ADDR_W'(k))      coefBank[k] <= coefData;
    end

    assign preSum[k] = PRE_W'(taps[k]) + PRE_W'(taps[TAPS-1-k]);

    always_ff @(posedge clk) begin
      if (rst)                 prodReg[k] <= '0;
      else if (strobes.prodEn) prodReg[k] <= PROD_W'(coefBank[k]) * PROD_W'(preSum[k]);
    end

    AST_COEF_LOAD: assert property (@(posedge clk) disable iff (rst)
      (strobes.coefWe && coefAddr == ADDR_W'(k)) |=> (coefBank[k] == $past(coefData)))
      else $error("coef load"); // R5

    AST_COEF_KEEP: assert property (@(posedge clk) disable iff (rst)
      !strobes.coefWe |=> $stable(coefBank[k])) else $error("coef keep"); // R7

    AST_COEF_DEFAULT: assert property (@(posedge clk)
      $past(rst) |-> (coefBank[k] == COEF_W'(DEF_COEF))) else $error("coef default"); // R8
  end

  // Adder tree over the products.
  always_comb begin
    sumNext = '0;
    for (int k = 0; k < PAIRS; k++) sumNext = sumNext + SUM_W'(prodReg[k]);
  end

  always_ff @(posedge clk) begin
    if (rst)                sumReg <= '0;
    else if (strobes.sumEn) sumReg <= sumNext;
  end

  assign dataOut = sumReg;

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> ($stable(taps[0]) && $stable(taps[TAPS-1]))) else $error("shift"); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.sumEn |=> $stable(dataOut)) else $error("hold"); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (dataOut == '0)) else $error("reset out"); // R1

endmodule

// File: rtl/foldedFir.sv
module foldedFir
  import firPkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int COEF_W   = 10,
  parameter int TAPS     = 8,
  parameter int DEF_COEF = 65,
  localparam int PAIRS   = TAPS / 2,
  localparam int ADDR_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int SUM_W   = DATA_W + 1 + COEF_W + $clog2(PAIRS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              coefWe,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic [COEF_W-1:0] coefData,
  output logic              outValid,
  output logic [SUM_W-1:0]  dataOut
);

  ctrlStrobes_t strobes;

  firControl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .coefWe   (coefWe),
    .strobes  (strobes),
    .outValid (outValid)
  );

  firDatapath #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .TAPS     (TAPS),
    .DEF_COEF (DEF_COEF)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/foldedFir_tb.sv
module foldedFir_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [9:0]  dataIn = '0;
  logic        coefWe = 1'b0;
  logic [1:0]  coefAddr = '0;
  logic [9:0]  coefData = '0;
  logic        outValid;
  logic [22:0] dataOut;

  foldedFir dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .dataOut(dataOut)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  int coefM [4];
  int hist  [8];
  int expQ [$];
  int dueQ [$];
  string tagQ [$];
  int lastOut = 0;
  bit monOn = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model();
    int s = 0;
    for (int k = 0; k < 4; k++) s += coefM[k] * (hist[k] + hist[7-k]);
    return s;
  endfunction

  task automatic sendSample(int x, string tag);
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = 10'(x);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    expQ.push_back(model());
    dueQ.push_back(cyc + 3);
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      dataIn  = 10'($urandom_range(0, 1023));   // ignored while idle (R4)
    end
  endtask

  task automatic writeCoef(int a, int v);
    idle(4);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = 2'(a); coefData = 10'(v);
    coefM[a] = v;
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic doReset();
    idle(4);
    @(negedge clk);
    rst = 1'b1; monOn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    for (int k = 0; k < 4; k++) coefM[k] = 65;
    expQ.delete(); dueQ.delete(); tagQ.delete();
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 dataOut after reset", int'(dataOut), 0);
    lastOut = 0;
    monOn = 1'b1;
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R2 spurious outValid", 1, 0);
        end else begin
          check("R2 outValid cycle", cyc, dueQ[0]);
          check(tagQ[0], int'(dataOut), expQ[0]);
          void'(expQ.pop_front()); void'(dueQ.pop_front()); void'(tagQ.pop_front());
        end
        lastOut = int'(dataOut);
      end else begin
        if (dueQ.size() != 0 && dueQ[0] <= cyc) begin
          check("R2 missing outValid", 0, 1);
          void'(expQ.pop_front()); void'(dueQ.pop_front()); void'(tagQ.pop_front());
        end
        if (int'(dataOut) != lastOut) check("R4 dataOut hold", int'(dataOut), lastOut);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();

    // R1 / R3: impulse through default coefficients.
    sendSample(1, "R1 default impulse");
    for (int i = 0; i < 8; i++) sendSample(0, "R1 default impulse");
    idle(4);

    // R3 / R5: distinct coefficients reveal the tap-pair mapping.
    writeCoef(0, 1); writeCoef(1, 2); writeCoef(2, 4); writeCoef(3, 8);
    sendSample(1, "R3 mapping impulse");
    for (int i = 0; i < 8; i++) sendSample(0, "R3 mapping impulse");
    idle(4);

    // R3: ramp sweep across the sample range.
    for (int v = 0; v < 1024; v += 7) sendSample(v, "R3 ramp");
    idle(4);

    // R4: random stream with random gaps.
    for (int i = 0; i < 300; i++) begin
      sendSample($urandom_range(0, 1023), "R4 gapped stream");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    // R5: reloads of random coefficient sets.
    for (int r = 0; r < 6; r++) begin
      for (int a = 0; a < 4; a++) writeCoef(a, $urandom_range(0, 1023));
      for (int i = 0; i < 40; i++) sendSample($urandom_range(0, 1023), "R5 reload stream");
    end
    idle(4);

    // R7: strobe low, address and data toggling.
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      coefWe = 1'b0; coefAddr = 2'(a); coefData = 10'(a * 100 + 7);
    end
    for (int i = 0; i < 16; i++) sendSample($urandom_range(0, 1023), "R7 no-write stream");
    idle(4);

    // R6: full scale.
    for (int a = 0; a < 4; a++) writeCoef(a, 1023);
    for (int i = 0; i < 10; i++) sendSample(1023, "R6 full scale");
    idle(4);
    check("R6 full scale value", lastOut, 8372232);

    // R8: reset restores defaults.
    doReset();
    for (int i = 0; i < 12; i++) sendSample($urandom_range(0, 1023), "R8 defaults after reset");
    idle(6);
    check("R2 queue drained", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule